// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Near-Empty and Near-Full Flags

This block is a first-in first-out buffer of 9-bit words whose write side and read side run on independent clocks. The write side reports full and near-full status on the write clock, and the read side reports empty and near-empty status on the read clock. Pointers cross between the two domains as Gray code through two-flop synchronizers. Each side therefore sees the other side's progress a few cycles late, and a flag can only clear late, never early.

One shared input, `wr_aux`, is sampled while reset is held and sets the operating mode. If it is high during reset, it acts as a second, active-high write enable. If it is low during reset, the block runs in offset-programming mode. In that mode, driving `wr_aux` low redirects write strobes into the two threshold registers, and read strobes return the threshold values instead of popping data. Both thresholds reset to 7. The output enable does not drive a tri-state bus: when it is inactive, the read data is forced to zero and a valid output is dropped.

Top module: `dcf_fifo`

## Requirements
- R1: On a rising `wclk` edge with `wr_en_n` low, `wr_aux` high and `full_n` high, `wr_data` is stored. This holds in both modes. Words leave on `rd_data` in the order they were stored.
- R2: `full_n` is low exactly when DEPTH words are held. A write strobe while `full_n` is low stores nothing.
- R3: A word is popped on a rising `rclk` edge only when `rd_en_a_n` and `rd_en_b_n` are both low and `empty_n` is high. Otherwise `rd_data` holds its previous value.
- R4: While `rst_n` is low, both pointers return to location 0. `full_n` and `near_full_n` are high, and `empty_n` and `near_empty_n` are low.
- R5: If `wr_aux` is high during reset, the block is in two-enable mode. A strobe with `wr_en_n` low and `wr_aux` low then stores nothing and loads nothing.
- R6: If `wr_aux` is low during reset, the block is in offset mode. A write-clock edge with `wr_en_n` low and `wr_aux` low loads a threshold from `wr_data` and leaves the data memory untouched.
- R7: `near_empty_n` is low when the occupancy seen by the read side is at or below the empty threshold (7 after reset).
- R8: `near_full_n` is low when the free space seen by the write side is at or below the full threshold (7 after reset).
- R9: While `out_en_n` is high, `rd_data` is 0 and `rd_valid` is 0. While `out_en_n` is low, `rd_valid` is 1 and `rd_data` shows the output register.
- R10: Threshold loads alternate between the two registers, empty threshold first, then full threshold. Reset returns the sequence to the empty threshold.
- R11: In offset mode, with `wr_aux` low and both read enables low, the next `rclk` edge puts the selected threshold on `rd_data` without popping a word. The read-back sequence alternates in the same order as R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset; `wclk` must toggle while it is low so the mode can be sampled |
| wr_data | input | 9 | Write word or threshold load value |
| wr_en_n | input | 1 | Active-low write strobe |
| wr_aux | input | 1 | Shared pin: second write enable, or active-low threshold access |
| rd_en_a_n | input | 1 | Active-low read enable, first |
| rd_en_b_n | input | 1 | Active-low read enable, second |
| out_en_n | input | 1 | Active-low output enable |
| rd_data | output | 9 | Read word or threshold read-back value |
| rd_valid | output | 1 | High while the output is enabled |
| empty_n | output | 1 | Low when empty, on the read clock |
| near_empty_n | output | 1 | Low when near empty, on the read clock |
| full_n | output | 1 | Low when full, on the write clock |
| near_full_n | output | 1 | Low when near full, on the write clock |

## Verification
On every cycle, the assertions check the following:
- occupancy never exceeds DEPTH as seen from either side;
- the read pointer never moves while the block is empty;
- the write pointer never jumps by more than one;
- a full or empty condition always implies the matching near flag;
- the output enable gates the data and valid outputs.

Only the bench scenarios can show the rest:
- FIFO ordering across a full fill-and-drain;
- the exact counts at which each near flag switches, for both default and loaded thresholds;
- the mode selection at reset;
- the alternating order of threshold loads and read-backs.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int PTR_MAX = 16;
  typedef logic [PTR_MAX-1:0] ptr_t;
  typedef enum logic {SEL_EMPTY = 1'b0, SEL_FULL = 1'b1} ofs_sel_e;

  function automatic ptr_t bin2gray(input ptr_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic ptr_t gray2bin(input ptr_t g);
    ptr_t b;
    b[PTR_MAX-1] = g[PTR_MAX-1];
    for (int i = PTR_MAX - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // words held between a leading and a trailing pointer, modulo pointer width
  function automatic ptr_t occupancy(input ptr_t lead, input ptr_t trail, input int pw);
    ptr_t d;
    ptr_t mask;
    d    = lead - trail;
    mask = (ptr_t'(1) << pw) - ptr_t'(1);
    return d & mask;
  endfunction

  function automatic logic at_or_below(input ptr_t amount, input ptr_t thresh);
    return amount <= thresh;
  endfunction
endpackage

// File: rtl/dcf_sync2.sv
module dcf_sync2 #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage [2];

  for (genvar s = 0; s < 2; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage[s] <= '0;
      else if (s == 0) stage[s] <= d;
      else stage[s] <= stage[s-1];
    end
  end

  assign q = stage[1];
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int DW    = 9,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcf_wside.sv
module dcf_wside
  import dcf_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rst_n,
  input  logic          wr_en_n,
  input  logic          wr_aux,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] rgray_s,
  output logic [PW-1:0] wptr,
  output logic [PW-1:0] wgray,
  output logic [PW-1:0] wcount,
  output logic          wr_fire,
  output logic          ld_fire,
  output logic          prog_mode,
  output logic [DW-1:0] ofs_empty,
  output logic [DW-1:0] ofs_full,
  output logic          full_n,
  output logic          near_full_n
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [DW-1:0] OFS_DEF = DW'(7);

  ofs_sel_e      ld_sel;
  ptr_t          rbin_w, cnt_w, gray_w;
  logic [PW-1:0] rbin, free_w;

  // mode capture: sampled only while reset is held
  always_ff @(posedge wclk) begin
    if (!rst_n) prog_mode <= ~wr_aux;
  end

  assign rbin_w = gray2bin(ptr_t'(rgray_s));
  assign rbin   = rbin_w[PW-1:0];
  assign cnt_w  = occupancy(ptr_t'(wptr), ptr_t'(rbin), PW);
  assign wcount = cnt_w[PW-1:0];
  assign free_w = DEPTH_P - wcount;

  assign full_n      = ~(wcount == DEPTH_P);
  assign near_full_n = ~at_or_below(ptr_t'(free_w), ptr_t'(ofs_full));

  assign wr_fire = rst_n & ~wr_en_n & wr_aux & full_n;
  assign ld_fire = rst_n & prog_mode & ~wr_en_n & ~wr_aux;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) wptr <= '0;
    else if (wr_fire) wptr <= wptr + 1'b1;
  end

  assign gray_w = bin2gray(ptr_t'(wptr));
  assign wgray  = gray_w[PW-1:0];

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      ld_sel    <= SEL_EMPTY;
      ofs_empty <= OFS_DEF;
      ofs_full  <= OFS_DEF;
    end else if (ld_fire) begin
      if (ld_sel == SEL_EMPTY) ofs_empty <= wr_data;
      else ofs_full <= wr_data;
      ld_sel <= (ld_sel == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    end
  end
endmodule

// File: rtl/dcf_rside.sv
module dcf_rside
  import dcf_pkg::*;
#(
  parameter int DW    = 9,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic          out_en_n,
  input  logic          wr_aux,
  input  logic          prog_mode,
  input  logic [DW-1:0] ofs_empty,
  input  logic [DW-1:0] ofs_full,
  input  logic [PW-1:0] wgray_s,
  input  logic [DW-1:0] mem_q,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] rgray,
  output logic [PW-1:0] rcount,
  output logic          rd_fire,
  output logic          ofs_rd,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          empty_n,
  output logic          near_empty_n
);
  ofs_sel_e      rb_sel;
  ptr_t          wbin_w, cnt_w, gray_w;
  logic [PW-1:0] wbin;
  logic [DW-1:0] dq;

  assign wbin_w = gray2bin(ptr_t'(wgray_s));
  assign wbin   = wbin_w[PW-1:0];
  assign cnt_w  = occupancy(ptr_t'(wbin), ptr_t'(rptr), PW);
  assign rcount = cnt_w[PW-1:0];

  assign empty_n      = ~(rcount == '0);
  assign near_empty_n = ~at_or_below(ptr_t'(rcount), ptr_t'(ofs_empty));

  assign ofs_rd  = rst_n & prog_mode & ~wr_aux & ~rd_en_a_n & ~rd_en_b_n;
  assign rd_fire = rst_n & ~rd_en_a_n & ~rd_en_b_n & empty_n & ~ofs_rd;

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rptr   <= '0;
      dq     <= '0;
      rb_sel <= SEL_EMPTY;
    end else if (rd_fire) begin
      rptr <= rptr + 1'b1;
      dq   <= mem_q;
    end else if (ofs_rd) begin
      dq     <= (rb_sel == SEL_EMPTY) ? ofs_empty : ofs_full;
      rb_sel <= (rb_sel == SEL_EMPTY) ? SEL_FULL : SEL_EMPTY;
    end
  end

  assign gray_w   = bin2gray(ptr_t'(rptr));
  assign rgray    = gray_w[PW-1:0];
  assign rd_data  = out_en_n ? '0 : dq;
  assign rd_valid = ~out_en_n;
endmodule

// File: rtl/dcf_fifo.sv
module dcf_fifo #(
  parameter int DW    = 9,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_en_n,
  input  logic          wr_aux,
  input  logic          rd_en_a_n,
  input  logic          rd_en_b_n,
  input  logic          out_en_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          empty_n,
  output logic          near_empty_n,
  output logic          full_n,
  output logic          near_full_n
);
  logic [PW-1:0] wptr, rptr, wgray, rgray, wgray_s, rgray_s, wcount, rcount;
  logic          wr_fire, ld_fire, rd_fire, ofs_rd, prog_mode;
  logic [DW-1:0] ofs_empty, ofs_full, mem_q;

  dcf_wside #(.DW(DW), .DEPTH(DEPTH)) u_wside (
    .wclk(wclk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_aux(wr_aux),
    .wr_data(wr_data), .rgray_s(rgray_s), .wptr(wptr), .wgray(wgray),
    .wcount(wcount), .wr_fire(wr_fire), .ld_fire(ld_fire),
    .prog_mode(prog_mode), .ofs_empty(ofs_empty), .ofs_full(ofs_full),
    .full_n(full_n), .near_full_n(near_full_n)
  );

  dcf_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst_n(rst_n), .d(wgray), .q(wgray_s));
  dcf_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst_n(rst_n), .d(rgray), .q(rgray_s));

  dcf_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .wclk(wclk), .we(wr_fire), .waddr(wptr[AW-1:0]), .wdata(wr_data),
    .raddr(rptr[AW-1:0]), .rdata(mem_q)
  );

  dcf_rside #(.DW(DW), .DEPTH(DEPTH)) u_rside (
    .rclk(rclk), .rst_n(rst_n), .rd_en_a_n(rd_en_a_n), .rd_en_b_n(rd_en_b_n),
    .out_en_n(out_en_n), .wr_aux(wr_aux), .prog_mode(prog_mode),
    .ofs_empty(ofs_empty), .ofs_full(ofs_full), .wgray_s(wgray_s),
    .mem_q(mem_q), .rptr(rptr), .rgray(rgray), .rcount(rcount),
    .rd_fire(rd_fire), .ofs_rd(ofs_rd), .rd_data(rd_data),
    .rd_valid(rd_valid), .empty_n(empty_n), .near_empty_n(near_empty_n)
  );
endmodule

// File: rtl/dcf_fifo_chk.sv
module dcf_fifo_chk #(
  parameter int DW    = 9,
  parameter int DEPTH = 256,
  parameter int PW    = 9
) (
  input logic          wclk,
  input logic          rclk,
  input logic          rst_n,
  input logic          rd_en_a_n,
  input logic          rd_en_b_n,
  input logic          out_en_n,
  input logic [DW-1:0] rd_data,
  input logic          rd_valid,
  input logic          empty_n,
  input logic          near_empty_n,
  input logic          full_n,
  input logic          near_full_n,
  input logic [PW-1:0] wptr,
  input logic [PW-1:0] rptr,
  input logic [PW-1:0] wcount,
  input logic [PW-1:0] rcount
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  p_no_overflow_r2: assert property (@(posedge wclk) disable iff (!rst_n)
    wcount <= DEPTH_P);

  p_wptr_step_r1: assert property (@(posedge wclk) disable iff (!rst_n)
    1'b1 |=> (wptr == $past(wptr)) || (wptr == $past(wptr) + 1'b1));

  p_no_underflow_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    (!empty_n && !rd_en_a_n && !rd_en_b_n) |=> rptr == $past(rptr));

  p_rcount_bound_r3: assert property (@(posedge rclk) disable iff (!rst_n)
    rcount <= DEPTH_P);

  p_reset_flags_r4: assert property (@(posedge wclk)
    !rst_n |-> (full_n && near_full_n && wptr == '0));

  p_full_near_r8: assert property (@(posedge wclk) disable iff (!rst_n)
    !full_n |-> !near_full_n);

  p_empty_near_r7: assert property (@(posedge rclk) disable iff (!rst_n)
    !empty_n |-> !near_empty_n);

  p_oe_gate_r9: assert property (@(posedge rclk) disable iff (!rst_n)
    out_en_n |-> (!rd_valid && rd_data == '0));
endmodule

bind dcf_fifo dcf_fifo_chk #(.DW(DW), .DEPTH(DEPTH), .PW(PW)) u_chk (
  .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .rd_en_a_n(rd_en_a_n),
  .rd_en_b_n(rd_en_b_n), .out_en_n(out_en_n), .rd_data(rd_data),
  .rd_valid(rd_valid), .empty_n(empty_n), .near_empty_n(near_empty_n),
  .full_n(full_n), .near_full_n(near_full_n), .wptr(wptr), .rptr(rptr),
  .wcount(wcount), .rcount(rcount)
);

// File: tb/sim_dcf_fifo.sv
module sim_dcf_fifo;
  localparam int DW    = 9;
  localparam int DEPTH = 256;
  localparam int WP    = 8;
  localparam int RP    = 10;

  logic wclk = 1'b0, rclk = 1'b0, rst_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic wr_en_n = 1'b1, wr_aux = 1'b1, rd_en_a_n = 1'b1, rd_en_b_n = 1'b1, out_en_n = 1'b0;
  logic [DW-1:0] rd_data;
  logic rd_valid, empty_n, near_empty_n, full_n, near_full_n;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [DW-1:0] sb_q[$];

  always #(WP/2) wclk = ~wclk;
  always #(RP/2) rclk = ~rclk;

  dcf_fifo #(.DW(DW), .DEPTH(DEPTH)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_r(input int n);
    repeat (n) @(negedge rclk);
  endtask

  task automatic wait_w(input int n);
    repeat (n) @(negedge wclk);
  endtask

  task automatic do_reset(input logic mode_pin);
    @(negedge wclk);
    rst_n = 1'b0; wr_aux = mode_pin;
    wait_w(3);
    rst_n = 1'b1;
    wait_w(1);
    wr_aux = 1'b1;
    wait_r(2);
    sb_q.delete();
  endtask

  // driver: one strobe, expected item queued when a store should happen
  task automatic drv_write(input logic [DW-1:0] d, input logic aux_v);
    @(negedge wclk);
    wr_en_n = 1'b0; wr_aux = aux_v; wr_data = d;
    if (aux_v && full_n) sb_q.push_back(d);
    @(negedge wclk);
    wr_en_n = 1'b1; wr_aux = 1'b1;
  endtask

  // monitor: one read strobe, compares against scoreboard or against the held value
  task automatic mon_read(input logic a_n, input logic b_n, input string req);
    logic [DW-1:0] prev, exp;
    bit fire;
    @(negedge rclk);
    rd_en_a_n = a_n; rd_en_b_n = b_n;
    prev = rd_data;
    fire = !a_n && !b_n && empty_n;
    @(negedge rclk);
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1;
    if (fire) begin
      exp = (sb_q.size() > 0) ? sb_q.pop_front() : '0;
      chk(rd_data == exp, req, int'(rd_data), int'(exp));
    end else begin
      chk(rd_data == prev, req, int'(rd_data), int'(prev));
    end
  endtask

  task automatic ofs_read(input int exp, input string req);
    @(negedge rclk);
    wr_aux = 1'b0; rd_en_a_n = 1'b0; rd_en_b_n = 1'b0;
    @(negedge rclk);
    rd_en_a_n = 1'b1; rd_en_b_n = 1'b1; wr_aux = 1'b1;
    chk(int'(rd_data) == exp, req, int'(rd_data), exp);
  endtask

  initial begin
    #1 rst_n = 1'b0;
    wait_w(3);
    // R4 reset state
    chk(empty_n == 0 && near_empty_n == 0, "R4 empty flags", {empty_n, near_empty_n}, 0);
    chk(full_n == 1 && near_full_n == 1, "R4 full flags", {full_n, near_full_n}, 3);
    do_reset(1'b1);

    // R5 two-enable mode: second enable low blocks the write
    drv_write(9'h055, 1'b0);
    wait_r(6);
    chk(empty_n == 0, "R5 blocked write", empty_n, 0);

    // R1 / R7 fill to 7 then 8 words
    for (int i = 0; i < 7; i++) drv_write(DW'(9'h100 + i), 1'b1);
    wait_r(6);
    chk(empty_n == 1, "R1 not empty", empty_n, 1);
    chk(near_empty_n == 0, "R7 at threshold 7", near_empty_n, 0);
    drv_write(9'h1A5, 1'b1);
    wait_r(6);
    chk(near_empty_n == 1, "R7 above threshold", near_empty_n, 1);

    // R3 single enable does not pop
    mon_read(1'b0, 1'b1, "R3 one enable a");
    mon_read(1'b1, 1'b0, "R3 one enable b");
    for (int i = 0; i < 8; i++) mon_read(1'b0, 1'b0, "R1 order");
    wait_r(2);
    chk(empty_n == 0, "R3 drained", empty_n, 0);
    mon_read(1'b0, 1'b0, "R3 read while empty");

    // R9 output enable
    @(negedge rclk); out_en_n = 1'b1;
    @(negedge rclk);
    chk(rd_valid == 0 && rd_data == 0, "R9 disabled", int'(rd_data), 0);
    out_en_n = 1'b0;
    @(negedge rclk);
    chk(rd_valid == 1 && rd_data == 9'h1A5, "R9 enabled", int'(rd_data), 9'h1A5);

    // R8 / R2 full and near-full with default threshold
    do_reset(1'b1);
    for (int i = 0; i < DEPTH - 8; i++) drv_write(DW'(i * 3), 1'b1);
    @(negedge wclk);
    chk(near_full_n == 1, "R8 free 8", near_full_n, 1);
    drv_write(9'h0F0, 1'b1);
    chk(near_full_n == 0, "R8 free 7", near_full_n, 0);
    for (int i = 0; i < 6; i++) drv_write(DW'(9'h0F1 + i), 1'b1);
    chk(full_n == 1, "R2 one free", full_n, 1);
    drv_write(9'h1EE, 1'b1);
    chk(full_n == 0, "R2 full", full_n, 0);
    drv_write(9'h1FF, 1'b1);
    chk(sb_q.size() == DEPTH, "R2 write while full queued", sb_q.size(), DEPTH);
    wait_r(6);
    for (int i = 0; i < DEPTH; i++) mon_read(1'b0, 1'b0, "R2 drain order");
    wait_r(2);
    chk(empty_n == 0, "R2 no extra word", empty_n, 0);

    // offset mode
    do_reset(1'b0);
    @(negedge wclk);
    wr_en_n = 1'b0; wr_aux = 1'b0; wr_data = 9'd3;
    @(negedge wclk);
    wr_data = 9'd5;
    @(negedge wclk);
    wr_en_n = 1'b1; wr_aux = 1'b1;
    wait_r(6);
    chk(empty_n == 0, "R6 load leaves memory", empty_n, 0);
    ofs_read(3, "R11 readback empty threshold");
    ofs_read(5, "R11 readback full threshold");
    ofs_read(3, "R10 sequence wraps");
    for (int i = 0; i < 3; i++) drv_write(DW'(9'h020 + i), 1'b1);
    wait_r(6);
    chk(near_empty_n == 0, "R7 loaded threshold 3", near_empty_n, 0);
    drv_write(9'h023, 1'b1);
    wait_r(6);
    chk(near_empty_n == 1, "R7 loaded above", near_empty_n, 1);
    for (int i = 0; i < 4; i++) mon_read(1'b0, 1'b0, "R1 offset-mode order");
    wait_w(6);
    for (int i = 0; i < DEPTH - 6; i++) drv_write(DW'(i), 1'b1);
    @(negedge wclk);
    chk(near_full_n == 1, "R8 loaded free 6", near_full_n, 1);
    drv_write(9'h011, 1'b1);
    chk(near_full_n == 0, "R8 loaded free 5", near_full_n, 0);

    // R10 reset restarts sequence at the empty threshold, defaults restored
    do_reset(1'b0);
    ofs_read(7, "R10 after reset empty");
    ofs_read(7, "R10 after reset full");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * WP);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule